// File: doc/BRIEF.md
# Colour-Band Video Test Pattern Generator

This block produces raster timing for a 640x480 display and a 12-bit pixel colour for every pixel clock. The core clock runs faster than the pixel rate, and a clock-enable marks the cycles on which the raster advances. Three picture modes are available: eight colour bands stacked vertically, the same eight bands side by side, or a pixel passed through unchanged from an external overlay renderer, such as a bouncing-square screensaver. The current pixel coordinates are brought out so that the overlay renderer can work out its own colour.

A single-cycle pulse from a debounced button moves the requested mode one step around a three-position ring. The displayed mode takes the requested value only at the frame boundary, so a picture never changes part-way down the screen.

The raster dimensions are parameters. Their defaults give an 800-clock line and a 525-line frame.

Top module: `stripe_pattern_gen`

## Requirements
- R1: After reset the coordinates are x=0, y=0, both syncs are high, and the displayed and requested modes are both 0 (horizontal bands).
- R2: On each cycle with `pix_en` high, x advances by one and wraps from H_TOTAL-1 (799) to 0. y advances by one only on that wrap, and it wraps from V_TOTAL-1 (524 by default) to 0. With `pix_en` low, neither counter changes.
- R3: `hsync` is low for x from H_ACTIVE+H_FP to H_ACTIVE+H_FP+H_SYNC-1 (656 to 751) and high for every other x.
- R4: `vsync` is low for y from V_ACTIVE+V_FP to V_ACTIVE+V_FP+V_SYNC-1 (490 and 491 by default) and high on every other line.
- R5: `active` is high exactly when x < H_ACTIVE and y < V_ACTIVE. When `active` is low, `rgb` is 12'h000. The output is never high-impedance.
- R6: The visible area is split into eight equal bands numbered 0 to 7. Their colours are red, blue, green, blue, red, green, red, blue, encoded as red 12'hF00, green 12'h0F0 and blue 12'h00F (bits 11:8 red, 7:4 green, 3:0 blue).
- R7: In mode 0 the bands stack from top to bottom. Band index = y / (V_ACTIVE/8), which gives bands 60 lines tall by default.
- R8: In mode 1 the bands run from left to right. Band index = x / (H_ACTIVE/8), which gives bands 80 pixels wide.
- R9: In mode 2, `rgb` equals `ovl_rgb` for every active pixel.
- R10: Each cycle with `mode_step` high moves the requested mode one step in the order 0 -> 1 -> 2 -> 0. Several pulses within one frame all count.
- R11: The displayed mode loads the requested mode only on the `pix_en` cycle at the last pixel of the last line. Pixels earlier in the frame keep the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate enable; the raster advances on cycles where it is high |
| mode_step | input | 1 | One-cycle pulse that advances the requested mode |
| ovl_rgb | input | 12 | Overlay pixel colour shown in mode 2 |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| rgb | output | 12 | Pixel colour, 4 bits per channel |
| active | output | 1 | High inside the visible area |
| pix_x | output | XW (10) | Current pixel column |
| pix_y | output | YW (10) | Current line |

## Verification
Several properties are checked on every cycle by the bound checker: the counter wrap and line step, counter hold while the enable is low, the sync pulse edges, and black output outside the visible area. Some behaviour has no property and can only be shown by the bench's scenarios: the band colours at chosen coordinates in each mode, the overlay pass-through, the mode ring order, and the deferral of a mode change to the next frame. The same applies to the case where two pulses in one frame add up to two steps. The bench shortens the frame vertically so that it can visit many frames.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    typedef logic [11:0] rgb_t;

    localparam rgb_t RGB_RED = 12'hF00;
    localparam rgb_t RGB_GRN = 12'h0F0;
    localparam rgb_t RGB_BLU = 12'h00F;
    localparam rgb_t RGB_BLK = 12'h000;

    localparam int NUM_BANDS = 8;

    typedef enum logic [1:0] {
        MODE_HBANDS  = 2'd0,
        MODE_VBANDS  = 2'd1,
        MODE_OVERLAY = 2'd2
    } mode_e;

    // Colour of band idx; the sequence is fixed.
    function automatic rgb_t band_colour(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd4, 3'd6: band_colour = RGB_RED;
            3'd2, 3'd5:       band_colour = RGB_GRN;
            default:          band_colour = RGB_BLU;
        endcase
    endfunction

    // Mode ring: 0 -> 1 -> 2 -> 0
    function automatic mode_e mode_after(input mode_e m);
        case (m)
            MODE_HBANDS: mode_after = MODE_VBANDS;
            MODE_VBANDS: mode_after = MODE_OVERLAY;
            default:     mode_after = MODE_HBANDS;
        endcase
    endfunction

endpackage

// File: rtl/sg_timing.sv
module sg_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int XW       = 10,
    parameter int YW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          hsync,
    output logic          vsync,
    output logic          active,
    output logic          frame_end
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;

    localparam logic [XW-1:0] H_LAST = XW'(H_TOTAL - 1);
    localparam logic [XW-1:0] H_VIS  = XW'(H_ACTIVE);
    localparam logic [XW-1:0] HS_BEG = XW'(H_ACTIVE + H_FP);
    localparam logic [XW-1:0] HS_END = XW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [YW-1:0] V_LAST = YW'(V_TOTAL - 1);
    localparam logic [YW-1:0] V_VIS  = YW'(V_ACTIVE);
    localparam logic [YW-1:0] VS_BEG = YW'(V_ACTIVE + V_FP);
    localparam logic [YW-1:0] VS_END = YW'(V_ACTIVE + V_FP + V_SYNC);

    typedef struct packed {
        logic [XW-1:0] h;
        logic [YW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic h_last, v_last;

    assign h_last = (cnt_q.h == H_LAST);
    assign v_last = (cnt_q.v == V_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (pix_en) begin
            if (h_last) begin
                cnt_d.h = '0;
                cnt_d.v = v_last ? '0 : cnt_q.v + 1'b1;
            end else begin
                cnt_d.h = cnt_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign x         = cnt_q.h;
    assign y         = cnt_q.v;
    assign hsync     = !((cnt_q.h >= HS_BEG) && (cnt_q.h < HS_END));
    assign vsync     = !((cnt_q.v >= VS_BEG) && (cnt_q.v < VS_END));
    assign active    = (cnt_q.h < H_VIS) && (cnt_q.v < V_VIS);
    assign frame_end = pix_en && h_last && v_last;

endmodule

// File: rtl/sg_mode_ctl.sv
module sg_mode_ctl
    import stripe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  frame_end,
    output mode_e mode
);
    typedef struct packed {
        mode_e req;
        mode_e cur;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end) st_d.cur = st_q.req;
        if (step)      st_d.req = mode_after(st_q.req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{req: MODE_HBANDS, cur: MODE_HBANDS};
        else        st_q <= st_d;
    end

    assign mode = st_q.cur;

endmodule

// File: rtl/sg_pixel.sv
module sg_pixel
    import stripe_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int XW       = 10,
    parameter int YW       = 10
) (
    input  mode_e         mode,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          active,
    input  rgb_t          ovl,
    output rgb_t          rgb
);
    localparam int BAND_W = H_ACTIVE / NUM_BANDS;
    localparam int BAND_H = V_ACTIVE / NUM_BANDS;

    logic [XW-1:0] col_band;
    logic [YW-1:0] row_band;

    assign col_band = x / XW'(BAND_W);
    assign row_band = y / YW'(BAND_H);

    always_comb begin
        rgb = RGB_BLK;
        if (active) begin
            case (mode)
                MODE_HBANDS:  rgb = band_colour(row_band[2:0]);
                MODE_VBANDS:  rgb = band_colour(col_band[2:0]);
                MODE_OVERLAY: rgb = ovl;
                default:      rgb = RGB_BLK;
            endcase
        end
    end

endmodule

// File: rtl/stripe_pattern_gen.sv
module stripe_pattern_gen
    import stripe_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int XW       = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP),
    parameter int YW       = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          mode_step,
    input  logic [11:0]   ovl_rgb,
    output logic          hsync,
    output logic          vsync,
    output logic [11:0]   rgb,
    output logic          active,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y
);
    logic  frame_end;
    mode_e mode;

    sg_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .XW(XW), .YW(YW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .x(pix_x), .y(pix_y), .hsync(hsync), .vsync(vsync),
        .active(active), .frame_end(frame_end)
    );

    sg_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .step(mode_step),
        .frame_end(frame_end), .mode(mode)
    );

    sg_pixel #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .XW(XW), .YW(YW)
    ) u_pixel (
        .mode(mode), .x(pix_x), .y(pix_y), .active(active),
        .ovl(ovl_rgb), .rgb(rgb)
    );

endmodule

// File: rtl/stripe_pattern_gen_chk.sv
module stripe_pattern_gen_chk #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int XW       = 10,
    parameter int YW       = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          hsync,
    input logic          vsync,
    input logic [11:0]   rgb,
    input logic          active,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y
);
    localparam logic [XW-1:0] C_HLAST = XW'(H_ACTIVE + H_FP + H_SYNC + H_BP - 1);
    localparam logic [YW-1:0] C_VLAST = YW'(V_ACTIVE + V_FP + V_SYNC + V_BP - 1);
    localparam logic [XW-1:0] C_HSB   = XW'(H_ACTIVE + H_FP);
    localparam logic [XW-1:0] C_HSL   = XW'(H_ACTIVE + H_FP + H_SYNC - 1);
    localparam logic [YW-1:0] C_VSB   = YW'(V_ACTIVE + V_FP);
    localparam logic [XW-1:0] C_HVIS  = XW'(H_ACTIVE);

    // R2: line wrap and hold
    p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pix_x == C_HLAST) |=> (pix_x == '0));
    p_vstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pix_x == C_HLAST && pix_y != C_VLAST) |=> (pix_y == $past(pix_y) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(pix_x) && $stable(pix_y)));
    // R3: sync pulse edges
    p_hsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == C_HSB || pix_x == C_HSL) |-> !hsync);
    p_hsync_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == C_HSB - 1'b1 || pix_x == C_HSL + 1'b1) |-> hsync);
    // R4
    p_vsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_y == C_VSB) |-> !vsync);
    // R5: black outside the visible area
    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active || pix_x >= C_HVIS) |-> (rgb == 12'h000));

endmodule

bind stripe_pattern_gen stripe_pattern_gen_chk #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .XW(XW), .YW(YW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync),
    .vsync(vsync), .rgb(rgb), .active(active), .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/stripe_pattern_gen_bench.sv
module stripe_pattern_gen_bench;
    // Frame shortened vertically: 8 visible lines (one per band), 12 in total
    localparam int HA = 640, HF = 16, HS = 96, HB = 48;
    localparam int VA = 8, VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int XW = $clog2(HT);
    localparam int YW = $clog2(VT);
    localparam logic [11:0] OVL = 12'hA5C;
    localparam logic [11:0] RD = 12'hF00, GR = 12'h0F0, BL = 12'h00F, BK = 12'h000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic          mode_step = 1'b0;
    logic [11:0]   ovl_rgb = OVL;
    logic          hsync, vsync, active;
    logic [11:0]   rgb;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;

    int checks = 0;
    int errors = 0;
    int cur_mode = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stripe_pattern_gen #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
    ) u_stripe_pattern_gen (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_step(mode_step),
        .ovl_rgb(ovl_rgb), .hsync(hsync), .vsync(vsync), .rgb(rgb),
        .active(active), .pix_x(pix_x), .pix_y(pix_y)
    );

    // {mode[1:0], x[9:0], y[9:0], expected rgb[11:0]}
    localparam int NV = 27;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 10'd0,   10'd0, RD}, {2'd0, 10'd639, 10'd0, RD},
        {2'd0, 10'd640, 10'd0, BK}, {2'd0, 10'd5,   10'd1, BL},
        {2'd0, 10'd5,   10'd2, GR}, {2'd0, 10'd5,   10'd3, BL},
        {2'd0, 10'd5,   10'd4, RD}, {2'd0, 10'd5,   10'd5, GR},
        {2'd0, 10'd5,   10'd6, RD}, {2'd0, 10'd639, 10'd7, BL},
        {2'd0, 10'd10,  10'd8, BK},
        {2'd1, 10'd0,   10'd0, RD}, {2'd1, 10'd79,  10'd0, RD},
        {2'd1, 10'd80,  10'd0, BL}, {2'd1, 10'd160, 10'd3, GR},
        {2'd1, 10'd240, 10'd3, BL}, {2'd1, 10'd320, 10'd5, RD},
        {2'd1, 10'd400, 10'd5, GR}, {2'd1, 10'd480, 10'd6, RD},
        {2'd1, 10'd639, 10'd7, BL}, {2'd1, 10'd700, 10'd7, BK},
        {2'd1, 10'd100, 10'd8, BK},
        {2'd2, 10'd0,   10'd0, OVL}, {2'd2, 10'd639, 10'd7, OVL},
        {2'd2, 10'd640, 10'd7, BK},  {2'd2, 10'd0,   10'd8, BK},
        {2'd0, 10'd0,   10'd0, RD}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at x=%0d y=%0d", req, act, exp, pix_x, pix_y);
        end
    endtask

    task automatic wait_at(input int x, input int y);
        @(negedge clk);
        while (int'(pix_x) != x || int'(pix_y) != y) @(negedge clk);
    endtask

    task automatic pulse();
        @(posedge clk); #1 mode_step = 1'b1;
        @(posedge clk); #1 mode_step = 1'b0;
    endtask

    task automatic goto_mode(input int m);
        while (cur_mode != m) begin
            pulse();
            cur_mode = (cur_mode + 1) % 3;
        end
        wait_at(HT - 1, VT - 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 x", int'(pix_x), 0);
        check("R1 y", int'(pix_y), 0);
        check("R1 hsync", int'(hsync), 1);
        check("R1 vsync", int'(vsync), 1);
        check("R1 mode0 rgb", int'(rgb), int'(RD));
        // R2: hold with enable low
        repeat (4) @(negedge clk);
        check("R2 hold x", int'(pix_x), 0);
        pix_en = 1'b1;
        @(negedge clk);
        check("R2 step x", int'(pix_x), 1);
        // R3: hsync window
        wait_at(655, 0); check("R3 hsync 655", int'(hsync), 1);
        @(negedge clk);  check("R3 hsync 656", int'(hsync), 0);
        wait_at(751, 0); check("R3 hsync 751", int'(hsync), 0);
        @(negedge clk);  check("R3 hsync 752", int'(hsync), 1);
        wait_at(HT - 1, 0); @(negedge clk);
        check("R2 line step y", int'(pix_y), 1);
        check("R2 line wrap x", int'(pix_x), 0);
        // R4: vsync window
        wait_at(HT - 1, VA + VF - 1); check("R4 vsync before", int'(vsync), 1);
        @(negedge clk);               check("R4 vsync first", int'(vsync), 0);
        wait_at(HT - 1, VA + VF + VS - 1); check("R4 vsync last", int'(vsync), 0);
        @(negedge clk);               check("R4 vsync after", int'(vsync), 1);
        wait_at(HT - 1, VT - 1); @(negedge clk);
        check("R2 frame wrap y", int'(pix_y), 0);

        // R5..R10: table walk
        for (int i = 0; i < NV; i++) begin
            int m, vx, vy, ex;
            m  = int'(VEC[i][33:32]);
            vx = int'(VEC[i][31:22]);
            vy = int'(VEC[i][21:12]);
            ex = int'(VEC[i][11:0]);
            if (m != cur_mode) goto_mode(m);
            wait_at(vx, vy);
            check($sformatf("R6 R7 R8 R9 R10 mode%0d rgb", m), int'(rgb), ex);
            check("R5 active", int'(active), int'(vx < HA && vy < VA));
        end

        // R11: mode change waits for the frame boundary
        wait_at(100, 2);
        pulse(); cur_mode = 1;
        wait_at(100, 4);
        check("R11 old mode kept", int'(rgb), int'(RD));
        wait_at(100, 0);
        check("R11 new mode at frame start", int'(rgb), int'(BL));
        // R10: two pulses in one frame advance twice (1 -> 2 -> 0)
        wait_at(100, 2);
        pulse(); pulse(); cur_mode = 0;
        wait_at(100, 5);
        check("R10 mid-frame still mode1", int'(rgb), int'(BL));
        wait_at(100, 0);
        check("R10 double step to mode0", int'(rgb), int'(RD));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule